// File: doc/BRIEF.md
# Endpoint Configuration Register Space

This block holds the 256-byte configuration space of a single-function bus endpoint. A host-side access port carries byte, word or dword reads and writes at a byte offset. Every stored byte is paired with a fixed writable-bit mask. A write changes only the bits the mask allows and keeps every other bit at its old value. The masks therefore define which command bits software may toggle. They also define the alignment of the two memory base registers, because the low bits of each base register cannot be written.

The space is preset at reset with identity, class, command, status, base-register and interrupt-line values taken from module parameters. Some writes also emit one-cycle control pulses to downstream logic: a base-changed pulse carrying the new first base address, an init-enable pulse carrying a 3-bit code, and enable and disable pulses. When the revision parameter is 2 or more, a counter pair sits at offsets 0x54–0x57. Reading offset 0x54 advances the pair.

Top module: `cfgsp_top`

## Requirements
- R1: After reset, offsets 0x00–0x01 hold the vendor identifier and 0x02–0x03 the device identifier, both little-endian. 0x04–0x05 hold the command preset and 0x06–0x07 the status preset. 0x08 holds the revision, 0x09 the programming interface, 0x0A the subclass and 0x0B the class. 0x10–0x13 hold the first base preset with its low nibble forced to 0x8. 0x14–0x17 hold the second base preset with its low nibble cleared. 0x3C holds 0xFF. Every other byte is zero.
- R2: A write stores (data & mask) | (old & ~mask) in each addressed byte. The mask is zero everywhere except the bytes named in R3, R4 and R5, so all other bytes keep their value under any write.
- R3: The command word at 0x04–0x05 has write mask 0x0403 by default. The mask is a parameter.
- R4: The first base register at 0x10–0x13 has write mask 0xFF000000, which gives 16 MB alignment. Its low nibble always reads 0x8.
- R5: The second base register at 0x14–0x17 has write mask 0xFFFF0000, which gives 64 KB alignment.
- R6: The size code selects the access width: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. Lane i of the data carries the byte at offset+i. On reads, unused upper lanes return zero. A read answers with rsp_valid and rsp_rdata on the cycle after the request. Writes give no response.
- R7: A write covering any byte of 0x10–0x13 gives a one-cycle base_pulse on the next cycle. At that point base_value equals the updated first base register with its low four bits cleared.
- R8: A write covering offset 0x40 gives a one-cycle init_pulse on the next cycle. init_value holds the low three bits of the data byte written to 0x40.
- R9: A write covering 0xC0 gives a one-cycle enable_pulse, and a write covering 0xE0 gives a one-cycle disable_pulse, both on the next cycle.
- R10: With revision 2 or more, a read covering offset 0x54 adds one to a 16-bit oscillator count and subtracts one from a 16-bit bus count. Both counts start at zero. Bytes 0x54–0x57 read the value osc | ((bus << 16) & 0x0FFF0000), one byte per offset.
- R11: The counts advance at most once per access, and the returned bytes show the updated counts. A read that covers only 0x55–0x57 returns the current counts and leaves them unchanged.
- R12: With revision below 2, offsets 0x54–0x57 read their stored bytes, and reads there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code (R6) |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data, lane i for offset+i |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, lane i for offset+i |
| base_pulse | output | 1 | First base register was written |
| base_value | output | 32 | Updated first base address, low nibble clear |
| init_pulse | output | 1 | Offset 0x40 was written |
| init_value | output | 3 | Low three bits written to 0x40 |
| enable_pulse | output | 1 | Offset 0xC0 was written |
| disable_pulse | output | 1 | Offset 0xE0 was written |

## Verification
The assertions assume size-aligned accesses: a word offset is even and a dword offset is a multiple of four. Under that assumption an access never spans two dwords, so one access cannot cover both 0xC0 and 0xE0. The random stimulus picks an offset and then clears its low bits to match the chosen size. It mixes dwords around the command, base, interrupt, init, counter and enable/disable locations with fully random dwords. The directed part covers counter reads that start at 0x55, a second instance with revision 1, and writes of all-ones to the masked registers.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    localparam int SPACE_BYTES = 256;
    localparam int OFF_W       = $clog2(SPACE_BYTES);
    localparam int LANES       = 4;
    localparam int LANE_W      = $clog2(LANES);
    localparam int DATA_W      = 8 * LANES;

    localparam logic [OFF_W-1:0] OFF_CMD   = 8'h04;
    localparam logic [OFF_W-1:0] OFF_BASE0 = 8'h10;
    localparam logic [OFF_W-1:0] OFF_BASE1 = 8'h14;
    localparam logic [OFF_W-1:0] OFF_IRQ   = 8'h3C;
    localparam logic [OFF_W-1:0] OFF_INIT  = 8'h40;
    localparam logic [OFF_W-1:0] OFF_CNT   = 8'h54;
    localparam logic [OFF_W-1:0] OFF_EN    = 8'hC0;
    localparam logic [OFF_W-1:0] OFF_DIS   = 8'hE0;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_WIDE  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        acc_size_e         size;
        logic [OFF_W-1:0]  addr;
        logic [DATA_W-1:0] wdata;
    } cfg_req_t;

    function automatic logic [2:0] size_bytes(acc_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // true when byte offset 'off' lies inside [base, base+n)
    function automatic logic covers(logic [OFF_W-1:0] base, logic [2:0] n,
                                    logic [OFF_W-1:0] off);
        logic [OFF_W-1:0] d;
        d = off - base;
        return d < OFF_W'(n);
    endfunction

    function automatic logic [7:0] lane_of(logic [DATA_W-1:0] w,
                                           logic [LANE_W-1:0] l);
        return w[8*l +: 8];
    endfunction

    function automatic logic [7:0] write_mask(logic [OFF_W-1:0] off,
                                              logic [15:0] cmd_mask);
        case (off)
            OFF_CMD:            return cmd_mask[7:0];
            OFF_CMD + 8'd1:     return cmd_mask[15:8];
            OFF_BASE0 + 8'd3:   return 8'hFF;
            OFF_BASE1 + 8'd2:   return 8'hFF;
            OFF_BASE1 + 8'd3:   return 8'hFF;
            default:            return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgsp_store.sv
module cfgsp_store
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h1B2C,
    parameter logic [15:0] DEVICE_ID   = 16'h0002,
    parameter logic [7:0]  REV_ID      = 8'h02,
    parameter logic [7:0]  PROG_IF     = 8'h00,
    parameter logic [7:0]  SUBCLASS    = 8'h00,
    parameter logic [7:0]  CLASS_CODE  = 8'h04,
    parameter logic [15:0] CMD_INIT    = 16'h0002,
    parameter logic [15:0] STATUS_INIT = 16'h0080,
    parameter logic [15:0] CMD_MASK    = 16'h0403,
    parameter logic [31:0] BASE0_INIT  = 32'hD000_0000,
    parameter logic [31:0] BASE1_INIT  = 32'hE000_0000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  cfg_req_t              req,
    output logic [LANES-1:0][7:0] rd_bytes,
    output logic [31:0]           base0
);

    localparam logic [31:0] BASE0_PRESET = {BASE0_INIT[31:4], 4'h8};
    localparam logic [31:0] BASE1_PRESET = {BASE1_INIT[31:4], 4'h0};

    function automatic logic [7:0] preset(logic [OFF_W-1:0] off);
        case (off)
            8'h00: return VENDOR_ID[7:0];
            8'h01: return VENDOR_ID[15:8];
            8'h02: return DEVICE_ID[7:0];
            8'h03: return DEVICE_ID[15:8];
            8'h04: return CMD_INIT[7:0];
            8'h05: return CMD_INIT[15:8];
            8'h06: return STATUS_INIT[7:0];
            8'h07: return STATUS_INIT[15:8];
            8'h08: return REV_ID;
            8'h09: return PROG_IF;
            8'h0A: return SUBCLASS;
            8'h0B: return CLASS_CODE;
            8'h10: return BASE0_PRESET[7:0];
            8'h11: return BASE0_PRESET[15:8];
            8'h12: return BASE0_PRESET[23:16];
            8'h13: return BASE0_PRESET[31:24];
            8'h14: return BASE1_PRESET[7:0];
            8'h15: return BASE1_PRESET[15:8];
            8'h16: return BASE1_PRESET[23:16];
            8'h17: return BASE1_PRESET[31:24];
            OFF_IRQ: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    logic [7:0] mem [SPACE_BYTES];
    logic [2:0] nbytes;

    assign nbytes = size_bytes(req.size);

    always_ff @(posedge clk) begin
        for (int j = 0; j < SPACE_BYTES; j++) begin
            if (rst) begin
                mem[j] <= preset(OFF_W'(j));
            end else if (req.valid && req.write && covers(req.addr, nbytes, OFF_W'(j))) begin
                mem[j] <= (lane_of(req.wdata, LANE_W'(OFF_W'(j) - req.addr))
                           & write_mask(OFF_W'(j), CMD_MASK))
                        | (mem[j] & ~write_mask(OFF_W'(j), CMD_MASK));
            end
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            rd_bytes[i] = (3'(i) < nbytes) ? mem[req.addr + OFF_W'(i)] : 8'h00;
        end
    end

    assign base0 = {mem[OFF_BASE0 + 8'd3], mem[OFF_BASE0 + 8'd2],
                    mem[OFF_BASE0 + 8'd1], mem[OFF_BASE0]};

    p_base0_kind_r4: assert property (@(posedge clk) disable iff (rst)
        base0[3:0] == 4'h8);

    p_vendor_fixed_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable({mem[1], mem[0]}));

endmodule

// File: rtl/cfgsp_counter.sv
module cfgsp_counter #(
    parameter int CNT_W = 16,
    parameter int BUS_KEEP = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hit,
    output logic [31:0] cnt_now
);

    logic [CNT_W-1:0] osc_q, bus_q, osc_n, bus_n;

    assign osc_n = hit ? osc_q + CNT_W'(1) : osc_q;
    assign bus_n = hit ? bus_q - CNT_W'(1) : bus_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_q <= '0;
            bus_q <= '0;
        end else begin
            osc_q <= osc_n;
            bus_q <= bus_n;
        end
    end

    assign cnt_now = {{(32-CNT_W-BUS_KEEP){1'b0}}, bus_n[BUS_KEEP-1:0], osc_n};

    p_counts_balance_r10: assert property (@(posedge clk) disable iff (rst)
        CNT_W'(osc_q + bus_q) == '0);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(osc_q) && $stable(bus_q));

endmodule

// File: rtl/cfgsp_strobe.sv
module cfgsp_strobe
    import cfgsp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cfg_req_t req,
    output logic     base_p,
    output logic     init_p,
    output logic [2:0] init_v,
    output logic     en_p,
    output logic     dis_p
);

    logic [2:0] nbytes;
    logic       wr, hit_base, hit_init, hit_en, hit_dis;
    logic [7:0] init_byte;

    assign nbytes = size_bytes(req.size);
    assign wr     = req.valid && req.write;

    always_comb begin
        hit_base = 1'b0;
        for (int k = 0; k < 4; k++) begin
            hit_base = hit_base | covers(req.addr, nbytes, OFF_BASE0 + OFF_W'(k));
        end
    end

    assign hit_init  = covers(req.addr, nbytes, OFF_INIT);
    assign hit_en    = covers(req.addr, nbytes, OFF_EN);
    assign hit_dis   = covers(req.addr, nbytes, OFF_DIS);
    assign init_byte = lane_of(req.wdata, LANE_W'(OFF_INIT - req.addr));

    always_ff @(posedge clk) begin
        if (rst) begin
            base_p <= 1'b0;
            init_p <= 1'b0;
            init_v <= 3'd0;
            en_p   <= 1'b0;
            dis_p  <= 1'b0;
        end else begin
            base_p <= wr && hit_base;
            init_p <= wr && hit_init;
            if (wr && hit_init) init_v <= init_byte[2:0];
            en_p   <= wr && hit_en;
            dis_p  <= wr && hit_dis;
        end
    end

    p_en_dis_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({en_p, dis_p}));

    p_init_single_r8: assert property (@(posedge clk) disable iff (rst)
        init_p |=> !init_p || $past(wr && hit_init));

endmodule

// File: rtl/cfgsp_top.sv
module cfgsp_top
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h1B2C,
    parameter logic [15:0] DEVICE_ID   = 16'h0002,
    parameter logic [7:0]  REV_ID      = 8'h02,
    parameter logic [7:0]  PROG_IF     = 8'h00,
    parameter logic [7:0]  SUBCLASS    = 8'h00,
    parameter logic [7:0]  CLASS_CODE  = 8'h04,
    parameter logic [15:0] CMD_INIT    = 16'h0002,
    parameter logic [15:0] STATUS_INIT = 16'h0080,
    parameter logic [15:0] CMD_MASK    = 16'h0403,
    parameter logic [31:0] BASE0_INIT  = 32'hD000_0000,
    parameter logic [31:0] BASE1_INIT  = 32'hE000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [7:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        base_pulse,
    output logic [31:0] base_value,
    output logic        init_pulse,
    output logic [2:0]  init_value,
    output logic        enable_pulse,
    output logic        disable_pulse
);

    localparam bit HAS_CNT = (REV_ID >= 8'd2);

    cfg_req_t              req;
    logic [LANES-1:0][7:0] st_bytes;
    logic [31:0]           base0;
    logic [31:0]           cnt_now;
    logic [2:0]            nbytes;
    logic                  cnt_hit;
    logic [DATA_W-1:0]     rd_merge;

    assign req.valid = req_valid;
    assign req.write = req_write;
    assign req.size  = acc_size_e'(req_size);
    assign req.addr  = req_addr;
    assign req.wdata = req_wdata;
    assign nbytes    = size_bytes(req.size);

    cfgsp_store #(
        .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REV_ID(REV_ID),
        .PROG_IF(PROG_IF), .SUBCLASS(SUBCLASS), .CLASS_CODE(CLASS_CODE),
        .CMD_INIT(CMD_INIT), .STATUS_INIT(STATUS_INIT), .CMD_MASK(CMD_MASK),
        .BASE0_INIT(BASE0_INIT), .BASE1_INIT(BASE1_INIT)
    ) u_store (
        .clk(clk), .rst(rst), .req(req), .rd_bytes(st_bytes), .base0(base0)
    );

    assign cnt_hit = HAS_CNT && req_valid && !req_write
                     && covers(req_addr, nbytes, OFF_CNT);

    generate
        if (HAS_CNT) begin : g_cnt
            cfgsp_counter u_cnt (
                .clk(clk), .rst(rst), .hit(cnt_hit), .cnt_now(cnt_now)
            );
        end else begin : g_nocnt
            assign cnt_now = 32'h0;
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic [OFF_W-1:0] la;
            la = req_addr + OFF_W'(i);
            if (HAS_CNT && 3'(i) < nbytes && covers(OFF_CNT, 3'd4, la)) begin
                rd_merge[8*i +: 8] = lane_of(cnt_now, LANE_W'(la - OFF_CNT));
            end else begin
                rd_merge[8*i +: 8] = st_bytes[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) rsp_rdata <= rd_merge;
        end
    end

    cfgsp_strobe u_strobe (
        .clk(clk), .rst(rst), .req(req),
        .base_p(base_pulse), .init_p(init_pulse), .init_v(init_value),
        .en_p(enable_pulse), .dis_p(disable_pulse)
    );

    assign base_value = {base0[31:4], 4'h0};

    p_rsp_follows_read_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    p_base_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        base_pulse |-> base_value[3:0] == 4'h0);

    p_write_no_rsp_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write |=> !rsp_valid);

endmodule

// File: tb/cfgsp_top_test.sv
`timescale 1ns/1ps
module cfgsp_top_test;

    localparam logic [15:0] VEN = 16'h1B2C, DEV = 16'h0002;
    localparam logic [7:0]  REV = 8'h02;
    localparam logic [15:0] CMDI = 16'h0002, STI = 16'h0080, CMDM = 16'h0403;
    localparam logic [31:0] B0I = 32'hD000_0000, B1I = 32'hE000_0000;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0;
    logic [1:0] req_size = 0;
    logic [7:0] req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic rsp_valid, base_pulse, init_pulse, enable_pulse, disable_pulse;
    logic [31:0] rsp_rdata, base_value;
    logic [2:0] init_value;
    logic lo_rsp_valid, lo_base, lo_init, lo_en, lo_dis;
    logic [31:0] lo_rdata, lo_bval;
    logic [2:0] lo_ival;

    int checks = 0, fails = 0;
    logic [7:0] m [256];
    logic [15:0] osc = 0, bus = 0;

    always #5 clk = ~clk;

    cfgsp_top uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .base_pulse(base_pulse),
        .base_value(base_value), .init_pulse(init_pulse), .init_value(init_value),
        .enable_pulse(enable_pulse), .disable_pulse(disable_pulse));

    cfgsp_top #(.REV_ID(8'h01)) uut_lo (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(lo_rsp_valid), .rsp_rdata(lo_rdata), .base_pulse(lo_base),
        .base_value(lo_bval), .init_pulse(lo_init), .init_value(lo_ival),
        .enable_pulse(lo_en), .disable_pulse(lo_dis));

    function automatic logic [7:0] bmask(int o);
        if (o == 4) return CMDM[7:0];
        if (o == 5) return CMDM[15:8];
        if (o == 8'h13 || o == 8'h16 || o == 8'h17) return 8'hFF;
        return 8'h00;
    endfunction

    function automatic logic [7:0] binit(int o);
        logic [31:0] b0, b1;
        b0 = {B0I[31:4], 4'h8};
        b1 = {B1I[31:4], 4'h0};
        case (o)
            0: return VEN[7:0];   1: return VEN[15:8];
            2: return DEV[7:0];   3: return DEV[15:8];
            4: return CMDI[7:0];  5: return CMDI[15:8];
            6: return STI[7:0];   7: return STI[15:8];
            8: return REV;        8'h0B: return 8'h04;
            8'h10: return b0[7:0];  8'h11: return b0[15:8];
            8'h12: return b0[23:16]; 8'h13: return b0[31:24];
            8'h14: return b1[7:0];  8'h15: return b1[15:8];
            8'h16: return b1[23:16]; 8'h17: return b1[31:24];
            8'h3C: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic int nb(logic [1:0] s);
        return (s == 0) ? 1 : (s == 1) ? 2 : 4;
    endfunction

    function automatic bit inside_acc(int a, int n, int o);
        return ((o - a) & 8'hFF) < n;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // performs one access on the shared port, updates the model, checks uut
    task automatic acc(bit w, logic [1:0] sz, logic [7:0] a, logic [31:0] d,
                       output logic [31:0] got);
        int n;
        logic [31:0] exp_rd;
        logic [31:0] cv;
        bit eb, ei, ee, ed;
        logic [2:0] eiv;
        n = nb(sz);
        exp_rd = 0;
        eb = 0; ei = 0; ee = 0; ed = 0; eiv = 0;
        if (w) begin
            for (int i = 0; i < n; i++) begin
                int o;
                o = (a + i) & 8'hFF;
                m[o] = (d[8*i +: 8] & bmask(o)) | (m[o] & ~bmask(o));
                if (o >= 8'h10 && o <= 8'h13) eb = 1;
                if (o == 8'h40) begin ei = 1; eiv = d[8*i +: 3]; end
                if (o == 8'hC0) ee = 1;
                if (o == 8'hE0) ed = 1;
            end
        end else begin
            if (inside_acc(a, n, 8'h54)) begin osc = osc + 1; bus = bus - 1; end
            cv = {4'h0, bus[11:0], osc};
            for (int i = 0; i < n; i++) begin
                int o;
                o = (a + i) & 8'hFF;
                if (o >= 8'h54 && o <= 8'h57) exp_rd[8*i +: 8] = cv[8*(o - 8'h54) +: 8];
                else exp_rd[8*i +: 8] = m[o];
            end
        end
        @(negedge clk);
        req_valid = 1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        got = rsp_rdata;
        if (!w) begin
            check("R6 rsp_valid", {31'b0, rsp_valid}, 32'h1);
            check("R6/R10 read data", rsp_rdata, exp_rd);
        end else begin
            check("R6 no rsp on write", {31'b0, rsp_valid}, 32'h0);
            check("R7 base pulse", {31'b0, base_pulse}, {31'b0, eb});
            if (eb) check("R7 base value",
                          base_value, {m[8'h13], m[8'h12], m[8'h11], m[8'h10] & 8'hF0});
            check("R8 init pulse", {31'b0, init_pulse}, {31'b0, ei});
            if (ei) check("R8 init value", {29'b0, init_value}, {29'b0, eiv});
            check("R9 enable/disable", {30'b0, enable_pulse, disable_pulse}, {30'b0, ee, ed});
        end
    endtask

    initial begin
        logic [31:0] g;
        for (int i = 0; i < 256; i++) m[i] = binit(i);
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset sweep and explicit identity/interrupt values
        acc(0, 2'd2, 8'h00, 0, g); check("R1 ids", g, {DEV, VEN});
        acc(0, 2'd0, 8'h3C, 0, g); check("R1 irq line", g, 32'h0000_00FF);
        acc(0, 2'd1, 8'h0A, 0, g); check("R1 class/subclass", g, 32'h0000_0400);
        for (int a = 0; a < 256; a += 4) if (a != 8'h54) acc(0, 2'd2, 8'(a), 0, g);

        // R2: read-only bytes keep value
        acc(1, 2'd2, 8'h00, 32'h1234_5678, g);
        acc(0, 2'd2, 8'h00, 0, g); check("R2 vendor unchanged", g, {DEV, VEN});
        // R3: command mask
        acc(1, 2'd1, 8'h04, 32'hFFFF, g);
        acc(0, 2'd1, 8'h04, 0, g); check("R3 cmd set", g, 32'h0000_0403 | {16'h0, CMDI});
        acc(1, 2'd1, 8'h04, 32'h0000, g);
        acc(0, 2'd1, 8'h04, 0, g); check("R3 cmd clear", g, {16'h0, CMDI & ~CMDM});
        // R4/R7: base 0
        acc(1, 2'd2, 8'h10, 32'hFFFF_FFFF, g);
        acc(0, 2'd2, 8'h10, 0, g); check("R4 base0 all-ones", g, 32'hFF00_0008);
        acc(1, 2'd0, 8'h12, 32'h0000_00AB, g);
        // R5
        acc(1, 2'd2, 8'h14, 32'hFFFF_FFFF, g);
        acc(0, 2'd2, 8'h14, 0, g); check("R5 base1 all-ones", g, 32'hFFFF_0000);
        // R8 / R9
        acc(1, 2'd0, 8'h40, 32'h0000_000D, g);
        acc(1, 2'd2, 8'h40, 32'h0000_0006, g);
        acc(1, 2'd0, 8'hC0, 32'h0, g);
        acc(1, 2'd2, 8'hE0, 32'h0, g);
        // R10 / R11: counter
        acc(0, 2'd0, 8'h55, 0, g); check("R11 no advance at 0x55", g, 32'h0);
        acc(0, 2'd2, 8'h54, 0, g); check("R10 first read", g, 32'h0FFF_0001);
        acc(0, 2'd2, 8'h54, 0, g); check("R11 once per dword", g, 32'h0FFE_0002);
        acc(0, 2'd1, 8'h56, 0, g); check("R11 upper half held", g, 32'h0000_0FFE);
        acc(0, 2'd0, 8'h54, 0, g); check("R10 byte read", g, 32'h0000_0003);
        // R12: low-revision instance reads stored zeros, no side effect
        acc(0, 2'd2, 8'h54, 0, g);
        check("R12 lo counter area", lo_rdata, 32'h0);
        acc(0, 2'd2, 8'h54, 0, g);
        check("R12 lo counter area repeat", lo_rdata, 32'h0);
        acc(0, 2'd0, 8'h08, 0, g);
        check("R12 lo revision byte", lo_rdata, 32'h0000_0001);

        // constrained random mix
        begin
            logic [7:0] hot [12];
            hot = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h3C, 8'h40, 8'h54,
                    8'hC0, 8'hE0, 8'h50, 8'h0C};
            void'($urandom(32'h5EED));
            for (int k = 0; k < 600; k++) begin
                logic [1:0] sz;
                logic [7:0] a;
                sz = 2'($urandom % 4);
                a = ($urandom % 3 == 0) ? 8'($urandom) : hot[$urandom % 12] + 8'($urandom % 4);
                if (sz == 2'd1) a[0] = 1'b0;
                if (sz[1]) a[1:0] = 2'b00;
                acc(($urandom % 2) == 1, sz, a, $urandom, g);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule